// File: doc/BRIEF.md
# Dual-Width Peripheral Register Port

This block is a slave register port for a local microprocessor or peripheral. It gives access to a small bank of 32-bit operation registers and to an interrupt status/enable pair. The bus has an active-low chip select, separate active-low read and write strobes, four active-low byte enables, five word-address lines and a data bus. The data bus is modelled as an input bus, an output bus and an output-enable signal. All register updates happen on the rising edge of the bus clock.

A static mode pin sets the width of the data path. In the 32-bit setting, the byte enables mark the valid lanes. In the 16-bit setting, only the low 16 data lines carry data, and each 32-bit register is reached through two half-word cycles. The top byte-enable pin then acts as a half-word select, and the second-highest enable has no meaning.

Interrupt sources arrive as single-cycle pulses. Each pulse latches a status bit. Software clears a status bit by writing a one to it. The active-low interrupt output is asserted while any latched source is also enabled.

Top module: `dual_width_regport`

## Requirements
- R1: While reset (`rst_n` low at a clock edge) is applied, the block clears every register, including interrupt status and interrupt enable. After reset, `irq_n` is 1 and `dq_oe` is 0.
- R2: `dq_oe` is 1 only while `sel_n` and `rd_n` are both 0. Whenever `dq_oe` is 0, `dq_out` is all zeros.
- R3: A write takes place at each clock edge where `sel_n`=0 and `wr_n`=0. With `mode16`=0, byte lane k (bits 8k+7..8k) is written only when `be_n[k]`=0. Lanes that are not selected keep their value.
- R4: With `mode16`=0 and a read active, `dq_out` carries the whole 32-bit register selected by `adr`.
- R5: With `mode16`=1 and a read active, `dq_out[15:0]` carries the low half of the register when `be_n[3]`=0 and the high half when `be_n[3]`=1. `dq_out[31:16]` is 0.
- R6: With `mode16`=1, a write takes data from `dq_in[15:0]` and updates only the half selected by `be_n[3]`. Within that half, the low byte is written when `be_n[0]`=0 and the high byte when `be_n[1]`=0. `be_n[2]` has no effect.
- R7: When `sel_n`=1 or `wr_n`=1, no register changes, except for interrupt status bits set by events.
- R8: Index 0 is the interrupt status register. Index 1 is the interrupt enable register. Indices 2 to NUM_REGS-1 are general read/write registers. Interrupt bits sit at positions IRQ_SRCS-1..0, and the upper bits read as 0. An index at or above NUM_REGS reads as 0 and ignores writes. A one-cycle pulse on `irq_evt[i]` sets status bit i at that clock edge.
- R9: Writing a one to a status bit clears it. Writing a zero leaves it unchanged. If an event for a bit arrives in the same cycle as a clear of that bit, the bit stays set.
- R10: `irq_n` is 0 exactly when some status bit and the matching enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode16 | input | 1 | 0: 32-bit data path, 1: 16-bit data path |
| sel_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| be_n | input | 4 | Active-low byte enables; in 16-bit mode bit 3 is the half-word select |
| adr | input | ADDR_W | Register word index |
| dq_in | input | 32 | Write data from the bus |
| dq_out | output | 32 | Read data toward the bus |
| dq_oe | output | 1 | Data bus output enable |
| irq_evt | input | IRQ_SRCS | Single-cycle interrupt source pulses |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The embedded assertions check these behaviours on every cycle:
- the idle-bus zero on `dq_out`;
- the two half-word lane masks in 16-bit mode never mixing;
- the general registers holding still when no write is active;
- an event pulse always leaving its status bit set;
- a clear without a coincident event always dropping its bit;
- the post-reset state.

Other behaviours need the bench's scenarios. These include the exact byte-lane merge results for chosen enable patterns and the half-word read selection. They also include the ignored byte enable 2, the refusal of out-of-range and unstrobed writes, and the level of `irq_n` as enables and clears change.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int unsigned BUS_W  = 32;
  localparam int unsigned HALF_W = BUS_W / 2;
  localparam int unsigned LANES  = BUS_W / 8;

  typedef logic [BUS_W-1:0] word_t;
  typedef logic [LANES-1:0] lane_t;

  // Expand a per-lane enable into a per-bit mask.
  function automatic word_t lane_bits(lane_t lanes);
    word_t m;
    for (int b = 0; b < int'(LANES); b++) m[b*8 +: 8] = {8{lanes[b]}};
    return m;
  endfunction
endpackage

// File: rtl/rp_lane_map.sv
module rp_lane_map
  import rp_pkg::*;
(
  input  logic  mode16,
  input  lane_t be_n,
  input  word_t din,
  input  word_t rword,
  output lane_t lanes,
  output word_t wdata,
  output word_t rshaped
);
  logic half_hi;

  always_comb begin
    half_hi = be_n[LANES-1];
    if (mode16) begin
      // Half-word path: top enable picks the half, bit 2 is unused.
      lanes   = half_hi ? {~be_n[1:0], 2'b00} : {2'b00, ~be_n[1:0]};
      wdata   = {din[HALF_W-1:0], din[HALF_W-1:0]};
      rshaped = {{HALF_W{1'b0}}, half_hi ? rword[BUS_W-1:HALF_W] : rword[HALF_W-1:0]};
    end else begin
      lanes   = ~be_n;
      wdata   = din;
      rshaped = rword;
    end
  end
endmodule

// File: rtl/rp_reg_bank.sv
module rp_reg_bank
  import rp_pkg::*;
#(
  parameter int unsigned NUM_GP = 6,
  parameter int unsigned BASE   = 2,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] idx,
  input  lane_t             lanes,
  input  word_t             wdata,
  output word_t             rword
);
  logic [NUM_GP-1:0][BUS_W-1:0] regs;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      regs <= '0;
    end else if (we) begin
      for (int g = 0; g < int'(NUM_GP); g++) begin
        if (idx == ADDR_W'(int'(BASE) + g)) begin
          for (int b = 0; b < int'(LANES); b++) begin
            if (lanes[b]) regs[g][b*8 +: 8] <= wdata[b*8 +: 8];
          end
        end
      end
    end
  end

  always_comb begin
    rword = '0;
    for (int g = 0; g < int'(NUM_GP); g++) begin
      if (idx == ADDR_W'(int'(BASE) + g)) rword = regs[g];
    end
  end

  // R7
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(regs));
endmodule

// File: rtl/rp_irq_ctl.sv
module rp_irq_ctl #(
  parameter int unsigned N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] evt,
  input  logic [N_SRC-1:0] clr,
  input  logic [N_SRC-1:0] en_mask,
  input  logic [N_SRC-1:0] en_data,
  output logic [N_SRC-1:0] stat,
  output logic [N_SRC-1:0] en,
  output logic             irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat <= '0;
      en   <= '0;
    end else begin
      stat <= (stat & ~clr) | evt;
      en   <= (en & ~en_mask) | (en_data & en_mask);
    end
  end

  assign irq_n = ~|(stat & en);

  // R8
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |evt |=> ((stat & $past(evt)) == $past(evt)));

  // R9
  clear_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |(clr & ~evt) |=> ((stat & $past(clr & ~evt)) == '0));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (stat == '0 && en == '0 && irq_n));
endmodule

// File: rtl/dual_width_regport.sv
module dual_width_regport
  import rp_pkg::*;
#(
  parameter int unsigned NUM_REGS = 8,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned IRQ_SRCS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode16,
  input  logic                sel_n,
  input  logic                rd_n,
  input  logic                wr_n,
  input  logic [3:0]          be_n,
  input  logic [ADDR_W-1:0]   adr,
  input  logic [31:0]         dq_in,
  output logic [31:0]         dq_out,
  output logic                dq_oe,
  input  logic [IRQ_SRCS-1:0] irq_evt,
  output logic                irq_n
);
  localparam int unsigned STAT_IDX = 0;
  localparam int unsigned EN_IDX   = 1;
  localparam int unsigned GP_BASE  = 2;
  localparam int unsigned NUM_GP   = NUM_REGS - GP_BASE;

  logic                wr_acc, rd_acc;
  lane_t               lanes;
  word_t               wdata, bitmask, rword, gp_word, rshaped;
  logic [IRQ_SRCS-1:0] stat, en, clr, en_mask;

  assign wr_acc = !sel_n && !wr_n;
  assign rd_acc = !sel_n && !rd_n;

  rp_lane_map u_lanes (
    .mode16 (mode16),
    .be_n   (be_n),
    .din    (dq_in),
    .rword  (rword),
    .lanes  (lanes),
    .wdata  (wdata),
    .rshaped(rshaped)
  );

  assign bitmask = lane_bits(lanes);

  rp_reg_bank #(.NUM_GP(NUM_GP), .BASE(GP_BASE), .ADDR_W(ADDR_W)) u_bank (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (wr_acc),
    .idx  (adr),
    .lanes(lanes),
    .wdata(wdata),
    .rword(gp_word)
  );

  always_comb begin
    word_t m;
    m       = wdata & bitmask;
    clr     = (wr_acc && adr == ADDR_W'(STAT_IDX)) ? m[IRQ_SRCS-1:0] : '0;
    en_mask = (wr_acc && adr == ADDR_W'(EN_IDX)) ? bitmask[IRQ_SRCS-1:0] : '0;
  end

  rp_irq_ctl #(.N_SRC(IRQ_SRCS)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (irq_evt),
    .clr    (clr),
    .en_mask(en_mask),
    .en_data(wdata[IRQ_SRCS-1:0]),
    .stat   (stat),
    .en     (en),
    .irq_n  (irq_n)
  );

  always_comb begin
    rword = gp_word;
    if (adr == ADDR_W'(STAT_IDX)) begin
      rword = '0;
      rword[IRQ_SRCS-1:0] = stat;
    end else if (adr == ADDR_W'(EN_IDX)) begin
      rword = '0;
      rword[IRQ_SRCS-1:0] = en;
    end
  end

  assign dq_oe  = rd_acc;
  assign dq_out = rd_acc ? rshaped : '0;

  // R2
  quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_out == '0));

  // R6
  half_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode16 |-> (lanes[3:2] == 2'b00 || lanes[1:0] == 2'b00));
endmodule

// File: tb/dual_width_regport_tb_top.sv
module dual_width_regport_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, mode16, sel_n, rd_n, wr_n;
  logic [3:0]  be_n;
  logic [4:0]  adr;
  logic [31:0] dq_in, dq_out;
  logic        dq_oe, irq_n;
  logic [7:0]  irq_evt;

  int n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  dual_width_regport dut_i (
    .clk(clk), .rst_n(rst_n), .mode16(mode16), .sel_n(sel_n), .rd_n(rd_n),
    .wr_n(wr_n), .be_n(be_n), .adr(adr), .dq_in(dq_in), .dq_out(dq_out),
    .dq_oe(dq_oe), .irq_evt(irq_evt), .irq_n(irq_n)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expectation per driven read cycle.
  always @(negedge clk) begin
    if (dq_oe === 1'b1) begin
      if (exp_q.size() > 0) chk(tag_q.pop_front(), dq_out, exp_q.pop_front());
      else chk("R2 unexpected drive", {31'b0, dq_oe}, 32'h0);
    end
  end

  task automatic idle();
    sel_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; be_n = 4'hF;
  endtask

  task automatic wr32(int a, logic [31:0] d, logic [3:0] ben);
    @(posedge clk); #2;
    mode16 = 1'b0; sel_n = 1'b0; wr_n = 1'b0; adr = 5'(a); dq_in = d; be_n = ben;
    @(posedge clk); #2; idle();
  endtask

  task automatic wr16(int a, logic hi, logic [15:0] d, logic [1:0] b10, logic b2);
    @(posedge clk); #2;
    mode16 = 1'b1; sel_n = 1'b0; wr_n = 1'b0; adr = 5'(a);
    dq_in = {16'hDEAD, d}; be_n = {hi, b2, b10};
    @(posedge clk); #2; idle();
  endtask

  task automatic rd(int a, logic m16, logic hi, logic [31:0] exp, string tag);
    @(posedge clk); #2;
    exp_q.push_back(exp); tag_q.push_back(tag);
    mode16 = m16; sel_n = 1'b0; rd_n = 1'b0; adr = 5'(a); be_n = {hi, 3'b000};
    @(posedge clk); #2; idle();
  endtask

  task automatic pulse(logic [7:0] e);
    @(posedge clk); #2; irq_evt = e;
    @(posedge clk); #2; irq_evt = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode16 = 1'b0; adr = '0; dq_in = '0; irq_evt = '0; idle();
    repeat (3) @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq_n after reset", {31'b0, irq_n}, 32'h1);
    chk("R1 dq_oe after reset", {31'b0, dq_oe}, 32'h0);
    for (int i = 0; i < 8; i++) rd(i, 1'b0, 1'b0, 32'h0, "R1 register cleared");

    // R3/R4: full and partial 32-bit writes
    wr32(2, 32'hA1B2C3D4, 4'h0);
    rd(2, 1'b0, 1'b0, 32'hA1B2C3D4, "R4 full word read");
    wr32(3, 32'hFFFFFFFF, 4'h0);
    wr32(3, 32'h11223344, 4'b1010);
    rd(3, 1'b0, 1'b0, 32'hFF22FF44, "R3 byte lane merge");

    // R5: half-word reads
    rd(2, 1'b1, 1'b0, 32'h0000C3D4, "R5 low half read");
    rd(2, 1'b1, 1'b1, 32'h0000A1B2, "R5 high half read");

    // R6: half-word writes, be_n[2] ignored both ways
    wr32(4, 32'h55667788, 4'h0);
    wr16(4, 1'b1, 16'hBEEF, 2'b00, 1'b0);
    rd(4, 1'b0, 1'b0, 32'hBEEF7788, "R6 high half write");
    wr16(4, 1'b0, 16'h1234, 2'b10, 1'b1);
    rd(4, 1'b0, 1'b0, 32'hBEEF7734, "R6 low byte only");

    // R7: strobes not both active
    @(posedge clk); #2; mode16 = 1'b0; sel_n = 1'b1; wr_n = 1'b0; adr = 5'd2; dq_in = '0; be_n = 4'h0;
    @(posedge clk); #2; sel_n = 1'b0; wr_n = 1'b1;
    @(posedge clk); #2; idle();
    rd(2, 1'b0, 1'b0, 32'hA1B2C3D4, "R7 unstrobed write ignored");

    // R2: output enable only with select and read
    @(posedge clk); #2; sel_n = 1'b0; rd_n = 1'b1; adr = 5'd2;
    @(negedge clk);
    chk("R2 oe with select only", {31'b0, dq_oe}, 32'h0);
    chk("R2 data with select only", dq_out, 32'h0);
    @(posedge clk); #2; sel_n = 1'b1; rd_n = 1'b0;
    @(negedge clk);
    chk("R2 oe with read only", {31'b0, dq_oe}, 32'h0);
    @(posedge clk); #2; idle();

    // R8: out-of-range index
    wr32(9, 32'hFFFFFFFF, 4'h0);
    rd(9, 1'b0, 1'b0, 32'h0, "R8 out-of-range reads zero");
    rd(2, 1'b0, 1'b0, 32'hA1B2C3D4, "R8 out-of-range write ignored");

    // R8/R10: events and enables
    pulse(8'h05);
    @(negedge clk);
    chk("R10 irq_n with no enable", {31'b0, irq_n}, 32'h1);
    rd(0, 1'b0, 1'b0, 32'h00000005, "R8 status latched");
    wr32(1, 32'h00000004, 4'h0);
    @(negedge clk);
    chk("R10 irq_n enabled source", {31'b0, irq_n}, 32'h0);
    rd(1, 1'b0, 1'b0, 32'h00000004, "R8 enable readback");

    // R9: write-one-to-clear
    wr32(0, 32'h00000004, 4'h0);
    @(negedge clk);
    chk("R9 irq_n after clear", {31'b0, irq_n}, 32'h1);
    rd(0, 1'b0, 1'b0, 32'h00000001, "R9 only written bit cleared");

    // R9: set wins over simultaneous clear
    @(posedge clk); #2;
    mode16 = 1'b0; sel_n = 1'b0; wr_n = 1'b0; adr = 5'd0; dq_in = 32'h1; be_n = 4'h0; irq_evt = 8'h01;
    @(posedge clk); #2; idle(); irq_evt = '0;
    rd(0, 1'b0, 1'b0, 32'h00000001, "R9 set beats clear");
    wr32(1, 32'h00000001, 4'h0);
    @(negedge clk);
    chk("R10 irq_n second source", {31'b0, irq_n}, 32'h0);

    // R1: reset mid-run
    @(posedge clk); #2; rst_n = 1'b0;
    @(posedge clk); #2; rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq_n after second reset", {31'b0, irq_n}, 32'h1);
    rd(2, 1'b0, 1'b0, 32'h0, "R1 general register cleared");
    rd(1, 1'b0, 1'b0, 32'h0, "R1 enable cleared");

    @(posedge clk); @(negedge clk);
    chk("R2 scoreboard drained", 32'(exp_q.size()), 32'h0);
    summary();
    $finish;
  end
endmodule